// File: doc/BRIEF.md
# Single-Channel Block Transfer Engine with Selectable Bus Release

This block copies a block of bytes between a fixed I/O device port and a run of system memory addresses, so the processor does not have to move each byte itself. Software first writes a byte count, a memory start address and a device port address. It then writes a command word that picks the direction and the bus release policy and arms the channel. Once armed, the engine waits for the device to request service. It then asks the processor for the system bus with a hold request and waits for the hold acknowledge before it drives any bus cycle.

Each byte takes one read cycle from the source, followed on the next clock by one write cycle to the destination. The release policy sets how long the engine keeps the bus. In single mode it gives the bus back after every byte. In burst mode it keeps the bus for up to a fixed number of bytes, set by a parameter. In bulk mode it keeps the bus until the whole block is done. When the count runs out, the engine raises an interrupt. The interrupt stays high until software writes the clear bit.

Top module: `dma_ctl`

## Requirements
- R1: Register offset 0 is the command word: bit 0 arms the channel, bit 1 selects direction (0 = device to memory, 1 = memory to device), bits 3:2 select the release policy (00 single, 01 burst, 10 bulk, 11 also bulk), and bit 4 clears the interrupt. Direction and policy are latched only by a write that arms an idle channel.
- R2: Offset 1 holds the byte count, offset 2 the memory start address and offset 3 the device port address. While the channel is armed, writes to offsets 1 to 3, and the arm, direction and policy fields of offset 0, have no effect.
- R3: hold_req is low after reset. It rises only when the channel is armed, the count is non-zero and dev_req is high.
- R4: bus_rd and bus_wr are asserted only while hold_ack is high. Every bus_rd cycle is followed on the next clock by a bus_wr cycle, and bus_io marks a device-port access.
- R5: In single mode, hold_req falls after each write cycle, so the number of bus grants equals the byte count.
- R6: In burst mode, the bus is kept for BURST_LEN bytes and then released. The last burst moves only the bytes that remain, so there are ceil(count / BURST_LEN) grants.
- R7: In bulk mode (policy 10 or 11), the bus is kept from the first byte to the last, with exactly one grant.
- R8: After hold_req falls, it stays low until hold_ack has been seen low.
- R9: The memory address rises by one after each byte, starting at the programmed value. The device port address stays fixed.
- R10: irq goes high on the clock after the last write cycle and stays high until a command write with bit 4 set. If completion and a clear fall in the same cycle, irq is set.
- R11: If the count is zero when the channel is armed, no bus request is made and irq goes high on the second clock after the arming write.
- R12: Each byte written equals the byte read in the cycle before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register offset |
| cfg_wdata | input | REG_W | Register write data |
| dev_req | input | 1 | Device service request |
| hold_req | output | 1 | Bus hold request to the processor |
| hold_ack | input | 1 | Bus hold acknowledge from the processor |
| bus_addr | output | ADDR_W | Bus address |
| bus_io | output | 1 | 1 = device port access, 0 = memory access |
| bus_rd | output | 1 | Read cycle strobe |
| bus_wr | output | 1 | Write cycle strobe |
| bus_wdata | output | DATA_W | Write data |
| bus_rdata | input | DATA_W | Read data, valid in the read cycle |
| irq | output | 1 | End-of-block interrupt |

## Verification
Two events can land in the same cycle: the completion that sets irq and a command write that clears it. The bench forces the overlap with a zero-count block. It arms the channel and, on the very next clock, writes the clear bit, which is the cycle in which the engine reports completion. irq must then read high, so the completion is not lost. A later lone clear must bring irq low.

// File: rtl/dma_pkg.sv
package dma_pkg;

  typedef enum logic [1:0] {
    XM_SINGLE   = 2'd0,
    XM_BURST    = 2'd1,
    XM_BULK     = 2'd2,
    XM_BULK_ALT = 2'd3
  } xfer_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_REQ  = 3'd1,
    ST_RD   = 3'd2,
    ST_WR   = 3'd3,
    ST_REL  = 3'd4
  } bus_state_e;

  localparam logic [1:0] OFS_CMD = 2'd0;
  localparam logic [1:0] OFS_CNT = 2'd1;
  localparam logic [1:0] OFS_MEM = 2'd2;
  localparam logic [1:0] OFS_IO  = 2'd3;

  localparam int CMD_START   = 0;
  localparam int CMD_DIR     = 1;
  localparam int CMD_MODE_LO = 2;
  localparam int CMD_IRQ_CLR = 4;
  localparam int CMD_BITS    = 5;

endpackage

// File: rtl/dma_cmd_regs.sv
module dma_cmd_regs
  import dma_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [1:0]          cfg_addr,
  input  logic [CMD_BITS-1:0] cmd_bits,
  input  logic                done,
  output logic                armed,
  output logic                dir_m2io,
  output xfer_mode_e          mode,
  output logic                irq
);

  logic       cmd_wr;
  logic       arm_set;
  logic       irq_clr;
  logic       armed_d;
  logic       irq_d;

  assign cmd_wr  = cfg_we && (cfg_addr == OFS_CMD);
  assign arm_set = cmd_wr && !armed && cmd_bits[CMD_START];
  assign irq_clr = cmd_wr && cmd_bits[CMD_IRQ_CLR];

  always_comb begin
    armed_d = armed;
    if (done)
      armed_d = 1'b0;
    else if (arm_set)
      armed_d = 1'b1;
  end

  // completion wins over a clear in the same cycle
  always_comb begin
    irq_d = irq;
    if (done)
      irq_d = 1'b1;
    else if (irq_clr)
      irq_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
      irq   <= 1'b0;
    end else begin
      armed <= armed_d;
      irq   <= irq_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_m2io <= 1'b0;
      mode     <= XM_SINGLE;
    end else if (arm_set) begin
      dir_m2io <= cmd_bits[CMD_DIR];
      mode     <= xfer_mode_e'(cmd_bits[CMD_MODE_LO +: 2]);
    end
  end

endmodule

// File: rtl/dma_addr_cnt.sv
module dma_addr_cnt
  import dma_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16,
  parameter int REG_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_addr,
  input  logic [REG_W-1:0]  cfg_wdata,
  input  logic              armed,
  input  logic              step,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [ADDR_W-1:0] io_addr,
  output logic              cnt_zero,
  output logic              cnt_last
);

  logic [CNT_W-1:0]  count;
  logic [CNT_W-1:0]  count_d;
  logic [ADDR_W-1:0] mem_d;
  logic [ADDR_W-1:0] io_d;
  logic              ld_cnt;
  logic              ld_mem;
  logic              ld_io;

  assign ld_cnt = cfg_we && !armed && (cfg_addr == OFS_CNT);
  assign ld_mem = cfg_we && !armed && (cfg_addr == OFS_MEM);
  assign ld_io  = cfg_we && !armed && (cfg_addr == OFS_IO);

  always_comb begin
    count_d = count;
    mem_d   = mem_addr;
    io_d    = io_addr;
    if (ld_cnt)
      count_d = cfg_wdata[CNT_W-1:0];
    else if (step)
      count_d = count - 1'b1;
    if (ld_mem)
      mem_d = cfg_wdata[ADDR_W-1:0];
    else if (step)
      mem_d = mem_addr + 1'b1;
    if (ld_io)
      io_d = cfg_wdata[ADDR_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count    <= '0;
      mem_addr <= '0;
      io_addr  <= '0;
    end else begin
      count    <= count_d;
      mem_addr <= mem_d;
      io_addr  <= io_d;
    end
  end

  assign cnt_zero = (count == '0);
  assign cnt_last = (count == CNT_W'(1));

endmodule

// File: rtl/dma_bus_fsm.sv
module dma_bus_fsm
  import dma_pkg::*;
#(
  parameter int BURST_LEN = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       armed,
  input  xfer_mode_e mode,
  input  logic       cnt_zero,
  input  logic       cnt_last,
  input  logic       dev_req,
  input  logic       hold_ack,
  output logic       hold_req,
  output logic       rd_cyc,
  output logic       wr_cyc,
  output logic       step,
  output logic       done
);

  localparam int BC_W = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1;
  localparam logic [BC_W-1:0] BC_LAST = BC_W'(BURST_LEN - 1);

  bus_state_e      state_q;
  bus_state_e      state_d;
  logic [BC_W-1:0] bcnt_q;
  logic [BC_W-1:0] bcnt_d;

  always_comb begin
    state_d = state_q;
    bcnt_d  = bcnt_q;
    step    = 1'b0;
    done    = 1'b0;
    case (state_q)
      ST_IDLE: begin
        bcnt_d = '0;
        if (armed) begin
          if (cnt_zero)
            done = 1'b1;
          else if (dev_req)
            state_d = ST_REQ;
        end
      end
      ST_REQ: begin
        if (hold_ack)
          state_d = ST_RD;
      end
      ST_RD: begin
        state_d = ST_WR;
      end
      ST_WR: begin
        step   = 1'b1;
        bcnt_d = bcnt_q + 1'b1;
        if (cnt_last) begin
          done    = 1'b1;
          state_d = ST_REL;
        end else begin
          case (mode)
            XM_SINGLE: state_d = ST_REL;
            XM_BURST:  state_d = (bcnt_q == BC_LAST) ? ST_REL : ST_RD;
            default:   state_d = ST_RD;
          endcase
        end
      end
      ST_REL: begin
        bcnt_d = '0;
        if (!hold_ack)
          state_d = ST_IDLE;
      end
      default: begin
        state_d = ST_IDLE;
        bcnt_d  = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      bcnt_q  <= '0;
    end else begin
      state_q <= state_d;
      bcnt_q  <= bcnt_d;
    end
  end

  assign hold_req = (state_q == ST_REQ) || (state_q == ST_RD) || (state_q == ST_WR);
  assign rd_cyc   = (state_q == ST_RD);
  assign wr_cyc   = (state_q == ST_WR);

endmodule

// File: rtl/dma_ctl.sv
module dma_ctl
  import dma_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int CNT_W     = 16,
  parameter int DATA_W    = 8,
  parameter int BURST_LEN = 16,
  localparam int REG_W    = (ADDR_W > CNT_W) ? ADDR_W : CNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_addr,
  input  logic [REG_W-1:0]  cfg_wdata,
  input  logic              dev_req,
  output logic              hold_req,
  input  logic              hold_ack,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_io,
  output logic              bus_rd,
  output logic              bus_wr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);

  logic              rst_s1;
  logic              rst_sync_n;
  logic              armed;
  logic              dir_m2io;
  xfer_mode_e        cur_mode;
  logic              fsm_done;
  logic              step;
  logic              rd_cyc;
  logic              wr_cyc;
  logic              cnt_zero;
  logic              cnt_last;
  logic [ADDR_W-1:0] mem_addr;
  logic [ADDR_W-1:0] io_addr;
  logic [DATA_W-1:0] byte_q;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_s1     <= 1'b1;
      rst_sync_n <= rst_s1;
    end
  end

  dma_cmd_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .cfg_we   (cfg_we),
    .cfg_addr (cfg_addr),
    .cmd_bits (cfg_wdata[CMD_BITS-1:0]),
    .done     (fsm_done),
    .armed    (armed),
    .dir_m2io (dir_m2io),
    .mode     (cur_mode),
    .irq      (irq)
  );

  dma_addr_cnt #(
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W),
    .REG_W  (REG_W)
  ) u_addr (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .armed     (armed),
    .step      (step),
    .mem_addr  (mem_addr),
    .io_addr   (io_addr),
    .cnt_zero  (cnt_zero),
    .cnt_last  (cnt_last)
  );

  dma_bus_fsm #(
    .BURST_LEN (BURST_LEN)
  ) u_fsm (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .armed    (armed),
    .mode     (cur_mode),
    .cnt_zero (cnt_zero),
    .cnt_last (cnt_last),
    .dev_req  (dev_req),
    .hold_ack (hold_ack),
    .hold_req (hold_req),
    .rd_cyc   (rd_cyc),
    .wr_cyc   (wr_cyc),
    .step     (step),
    .done     (fsm_done)
  );

  // byte captured in the read cycle, replayed in the write cycle
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)
      byte_q <= '0;
    else if (rd_cyc)
      byte_q <= bus_rdata;
  end

  always_comb begin
    bus_addr  = '0;
    bus_io    = 1'b0;
    bus_wdata = '0;
    if (rd_cyc) begin
      bus_addr = dir_m2io ? mem_addr : io_addr;
      bus_io   = !dir_m2io;
    end else if (wr_cyc) begin
      bus_addr  = dir_m2io ? io_addr : mem_addr;
      bus_io    = dir_m2io;
      bus_wdata = byte_q;
    end
  end

  assign bus_rd = rd_cyc;
  assign bus_wr = wr_cyc;

endmodule

// File: rtl/dma_ctl_chk.sv
module dma_ctl_chk
  import dma_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       hold_req,
  input logic       hold_ack,
  input logic       bus_rd,
  input logic       bus_wr,
  input logic       irq,
  input logic       done,
  input xfer_mode_e mode,
  input logic       cnt_zero,
  input logic       cfg_we,
  input logic [1:0] cfg_addr,
  input logic       clr_bit
);

  logic clr_wr;
  assign clr_wr = cfg_we && (cfg_addr == OFS_CMD) && clr_bit;

  // R4
  bus_needs_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd || bus_wr) |-> hold_ack);

  // R4
  rd_then_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> bus_wr);

  // R5
  single_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && mode == XM_SINGLE) |=> !hold_req);

  // R7
  bulk_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !done && (mode == XM_BULK || mode == XM_BULK_ALT)) |=> (hold_req && bus_rd));

  // R8
  no_rerequest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_req && hold_ack) |=> !hold_req);

  // R10
  irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> irq);

  // R10
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !clr_wr) |=> irq);

  // R11
  zero_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_req |-> !cnt_zero);

endmodule

bind dma_ctl dma_ctl_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .hold_req (hold_req),
  .hold_ack (hold_ack),
  .bus_rd   (bus_rd),
  .bus_wr   (bus_wr),
  .irq      (irq),
  .done     (fsm_done),
  .mode     (cur_mode),
  .cnt_zero (cnt_zero),
  .cfg_we   (cfg_we),
  .cfg_addr (cfg_addr),
  .clr_bit  (cfg_wdata[4])
);

// File: tb/dma_ctl_tb.sv
module dma_ctl_tb;

  localparam int ADDR_W = 16;
  localparam int BURST  = 16;

  typedef struct {
    logic        io;
    logic [15:0] addr;
    logic [7:0]  data;
  } item_t;

  logic        clk;
  logic        rst_n;
  logic        cfg_we;
  logic [1:0]  cfg_addr;
  logic [15:0] cfg_wdata;
  logic        dev_req;
  logic        hold_req;
  logic        hold_ack;
  logic [15:0] bus_addr;
  logic        bus_io;
  logic        bus_rd;
  logic        bus_wr;
  logic [7:0]  bus_wdata;
  logic [7:0]  bus_rdata;
  logic        irq;

  logic [7:0]  mem [256];
  int          io_rd_cnt;
  int          cyc;

  item_t exp_q[$];
  int    n_chk;
  int    n_fail;
  int    grants;
  int    last_wr_cyc;
  int    req_under_ack;
  int    bus_no_ack;
  logic  prev_req;

  dma_ctl #(.ADDR_W(ADDR_W), .CNT_W(16), .DATA_W(8), .BURST_LEN(BURST)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .dev_req(dev_req), .hold_req(hold_req), .hold_ack(hold_ack), .bus_addr(bus_addr),
    .bus_io(bus_io), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [7:0] io_byte(input int k);
    return 8'((k * 3 + 1) & 255);
  endfunction

  // processor: grants the bus one clock after the request, drops it one clock after release
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_ack <= 1'b0;
    else        hold_ack <= hold_req;
  end

  // memory and device models
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= 8'((i * 7 + 3) & 255);
      io_rd_cnt <= 0;
    end else begin
      if (bus_wr && !bus_io) mem[bus_addr[7:0]] <= bus_wdata;
      if (bus_rd && bus_io)  io_rd_cnt <= io_rd_cnt + 1;
    end
  end

  assign bus_rdata = bus_io ? io_byte(io_rd_cnt) : mem[bus_addr[7:0]];

  always @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    cfg_we    = 1'b1;
    cfg_addr  = a;
    cfg_wdata = d;
    @(negedge clk);
    cfg_we    = 1'b0;
  endtask

  function automatic logic [15:0] cmd(input bit start, input bit dir,
                                      input logic [1:0] mode, input bit clr);
    return {11'd0, clr, mode, dir, start};
  endfunction

  // scoreboard monitor
  task automatic monitor();
    item_t it;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (hold_req && !prev_req) begin
          grants++;
          if (hold_ack) req_under_ack++;
        end
        prev_req = hold_req;
        if ((bus_rd || bus_wr) && !hold_ack) bus_no_ack++;
        if (bus_wr) begin
          last_wr_cyc = cyc;
          if (exp_q.size() == 0) begin
            chk(1'b0, "R12", "unexpected write", bus_addr, 0);
          end else begin
            it = exp_q.pop_front();
            chk({bus_io, bus_addr} == {it.io, it.addr}, "R9", "write address",
                {bus_io, bus_addr}, {it.io, it.addr});
            chk(bus_wdata == it.data, "R12", "write data", bus_wdata, it.data);
          end
        end
      end
    end
  endtask

  task automatic wait_irq(output int at);
    int n = 0;
    while (!irq && n < 4000) begin
      @(negedge clk);
      n++;
    end
    at = cyc;
  endtask

  // driver: programs one block, queues the expected writes, checks grants and irq
  task automatic run_xfer(input bit dir, input logic [1:0] mode, input int cnt,
                          input logic [15:0] mbase, input logic [15:0] iop,
                          input int exp_grants, input int req_delay, input bit poke,
                          input string req);
    int g0;
    int irq_at;
    item_t it;
    cfg_write(2'd1, 16'(cnt));
    cfg_write(2'd2, mbase);
    cfg_write(2'd3, iop);
    for (int i = 0; i < cnt; i++) begin
      if (dir) begin
        it.io = 1'b1; it.addr = iop; it.data = mem[8'(mbase + 16'(i))];
      end else begin
        it.io = 1'b0; it.addr = mbase + 16'(i); it.data = io_byte(io_rd_cnt + i);
      end
      exp_q.push_back(it);
    end
    g0 = grants;
    if (req_delay > 0) dev_req = 1'b0;
    cfg_write(2'd0, cmd(1'b1, dir, mode, 1'b0));
    if (req_delay > 0) begin
      repeat (req_delay) @(negedge clk);
      // R3: no request while the device is silent
      chk(grants == g0 && !hold_req, "R3", "request without dev_req", grants - g0, 0);
      dev_req = 1'b1;
    end
    if (poke) begin
      repeat (3) @(negedge clk);
      // R2: these writes land while armed and must change nothing
      cfg_write(2'd1, 16'd2);
      cfg_write(2'd2, 16'h0F00);
      cfg_write(2'd0, cmd(1'b1, ~dir, 2'b00, 1'b0));
    end
    wait_irq(irq_at);
    chk(irq, "R10", {req, " irq at block end"}, irq, 1);
    chk(irq_at == last_wr_cyc + 1, "R10", "irq one clock after last write",
        irq_at, last_wr_cyc + 1);
    chk(grants - g0 == exp_grants, req, "bus grant count", grants - g0, exp_grants);
    chk(exp_q.size() == 0, "R2", "bytes left undelivered", exp_q.size(), 0);
    repeat (6) @(negedge clk);
    chk(irq, "R10", "irq held until cleared", irq, 1);
    cfg_write(2'd0, cmd(1'b0, 1'b0, 2'b00, 1'b1));
    chk(!irq, "R10", "irq after clear", irq, 0);
  endtask

  initial begin
    int g0;
    n_chk = 0; n_fail = 0; grants = 0; last_wr_cyc = 0;
    req_under_ack = 0; bus_no_ack = 0; prev_req = 1'b0;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0; dev_req = 1'b0;
    fork
      monitor();
      begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "R3", "watchdog expired", 0, 1);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
      end
    join_none
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R3 and R10: reset state
    chk(!hold_req && !bus_rd && !bus_wr, "R3", "bus idle after reset",
        {hold_req, bus_rd, bus_wr}, 0);
    chk(!irq, "R10", "irq low after reset", irq, 0);
    dev_req = 1'b1;

    // R5: single mode, device to memory, one grant per byte
    run_xfer(1'b0, 2'b00, 3, 16'h0120, 16'h0040, 3, 0, 1'b0, "R5");
    // R6: burst mode with a partial last burst (16+16+8)
    run_xfer(1'b1, 2'b01, 40, 16'h0200, 16'h0077, 3, 0, 1'b0, "R6");
    // R6: burst of exactly one full burst
    run_xfer(1'b1, 2'b01, 16, 16'h0310, 16'h0055, 1, 0, 1'b0, "R6");
    // R7 and R2: bulk, device to memory, with ignored writes while armed
    run_xfer(1'b0, 2'b10, 20, 16'h0480, 16'h0011, 1, 0, 1'b1, "R7");
    // R7 and R1: policy code 11 also runs as bulk, memory to device
    run_xfer(1'b1, 2'b11, 5, 16'h0480, 16'h0022, 1, 0, 1'b0, "R7");
    // R3: armed but device silent for a while; single mode
    run_xfer(1'b0, 2'b00, 2, 16'h0500, 16'h0033, 2, 12, 1'b0, "R5");

    // R11 and R10: zero count, with a clear landing on the completion cycle
    cfg_write(2'd1, 16'd0);
    g0 = grants;
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 2'd0; cfg_wdata = cmd(1'b1, 1'b0, 2'b10, 1'b0);
    @(negedge clk);
    cfg_wdata = cmd(1'b0, 1'b0, 2'b00, 1'b1);
    @(negedge clk);
    cfg_we = 1'b0;
    chk(irq, "R10", "completion beats simultaneous clear", irq, 1);
    repeat (4) @(negedge clk);
    chk(grants == g0 && !hold_req, "R11", "zero count made a request", grants - g0, 0);
    cfg_write(2'd0, cmd(1'b0, 1'b0, 2'b00, 1'b1));
    chk(!irq, "R10", "irq after lone clear", irq, 0);

    // R11: zero count without a clear, irq on the second clock after arming
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 2'd0; cfg_wdata = cmd(1'b1, 1'b1, 2'b01, 1'b0);
    @(negedge clk);
    cfg_we = 1'b0;
    chk(!irq, "R11", "irq one clock after arming", irq, 0);
    @(negedge clk);
    chk(irq, "R11", "irq two clocks after arming", irq, 1);
    cfg_write(2'd0, cmd(1'b0, 1'b0, 2'b00, 1'b1));

    chk(req_under_ack == 0, "R8", "request while acknowledge still high", req_under_ack, 0);
    chk(bus_no_ack == 0, "R4", "bus cycle without acknowledge", bus_no_ack, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule